// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command pins of one 16-bit SDRAM rank from reset until the device can carry normal traffic. It holds NOP while the supply and clock settle, then issues one precharge-all, a set number of auto-refresh commands and one mode-register load that puts the mode word on the address bus. It then raises a ready flag and starts a periodic refresh request for the memory controller that takes over the bus.

Every delay is a nanosecond parameter. At elaboration each one becomes whole clock cycles from the clock-frequency parameter. The refresh count is also a parameter. Two gives the short power-up sequence that many parts accept. Eight, with a 200 µs settle time, gives the longer industry-standard sequence. Each command is held off until the spacing required by the previous command has elapsed.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is high, the outputs are CKE low, NOP on the command pins, init_done low and refresh_req low.
- R2: CKE stays low through the first rising edge after reset is released and is high from the second edge onward. CS# is low in every cycle.
- R3: Precharge-all is issued exactly once, encoded CS#,RAS#,CAS#,WE# = 0,0,1,0, with address bit 10 high and the other address bits low. Before it come at least S cycles of NOP counted from reset release, where S is the settle time in cycles.
- R4: Exactly REFRESH_COUNT auto-refresh commands (0,0,0,1) follow, with a default of 2. The first comes exactly tRP cycles after the precharge, and each later one comes exactly tRFC cycles after the one before it.
- R5: One mode-register load (0,0,0,0) comes exactly tRFC cycles after the last refresh, with bank bits 0 and the address equal to the mode word. The default mode word is 0x023: bits [2:0] = 011 for burst 8, bit 3 = 0 for sequential order, and bits [6:4] = 010 for CAS latency 2.
- R6: Each delay in cycles is floor(ns × f_clk / 1e9), raised to 1 when the result is 0.
- R7: init_done rises exactly tMRD cycles after the mode-register load and then stays high. No further command is issued once it is high.
- R8: refresh_req is a one-cycle pulse. The first pulse comes tREFI cycles after init_done rises and each later pulse comes tREFI cycles after the one before. It never pulses while init_done is low.
- R9: Every cycle that does not carry one of the commands above drives NOP, encoded 0,1,1,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and the SDRAM |
| rst | input | 1 | Synchronous active-high reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address, held at 0 |
| sd_addr | output | ADDR_W | Address bus; carries A10 on precharge and the mode word on mode load |
| init_done | output | 1 | High once the sequence has finished |
| refresh_req | output | 1 | Single-cycle periodic refresh request |

## Verification
The hardest cases to reach from the ports are the long sequence with eight refreshes and a delay that converts to less than one cycle, because the default parameters exercise neither. The bench therefore runs a second instance alongside the default one. It has a 200 µs settle time, eight refreshes, a 10 ns tRP that truncates to 0 and must be raised to 1, and a 130 ns tRFC that truncates from 6.5 to 6. Both instances are watched cycle by cycle against command lists built from the requirements. Each run continues through three refresh pulses so that the first interval and the steady intervals are both checked.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP       = 2'd0,
    CMD_PRECHARGE = 2'd1,
    CMD_REFRESH   = 2'd2,
    CMD_LOAD_MODE = 2'd3
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_AFTER_PRE,
    ST_AFTER_REF,
    ST_AFTER_MODE,
    ST_READY
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_pins_t;

  function automatic sd_pins_t encode_cmd(input sd_cmd_e c);
    case (c)
      CMD_PRECHARGE: return sd_pins_t'(4'b0010);
      CMD_REFRESH:   return sd_pins_t'(4'b0001);
      CMD_LOAD_MODE: return sd_pins_t'(4'b0000);
      default:       return sd_pins_t'(4'b0111);
    endcase
  endfunction

  // floor(ns * hz / 1e9), never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned hz);
    logic [63:0] prod;
    prod = (64'(ns) * 64'(hz)) / 64'd1000000000;
    if (prod == 64'd0) return 1;
    return prod[31:0];
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_countdown.sv
module seq_countdown #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= W'(RST_VAL);
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int unsigned PERIOD = 390
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic tick
);

  localparam int unsigned CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == CW'(PERIOD - 1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  sd_cmd_e           cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);

  logic     armed_q;
  sd_pins_t pins_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cke     <= 1'b0;
      pins_q  <= encode_cmd(CMD_NOP);
      addr    <= '0;
    end else begin
      armed_q <= 1'b1;
      cke     <= armed_q;
      pins_q  <= encode_cmd(cmd_in);
      addr    <= addr_in;
    end
  end

  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 50_000_000,
  parameter int unsigned T_SETTLE_NS   = 100_000,
  parameter int unsigned REFRESH_COUNT = 2,
  parameter int unsigned T_RP_NS       = 20,
  parameter int unsigned T_RFC_NS      = 66,
  parameter int unsigned T_MRD_NS      = 20,
  parameter int unsigned T_REFI_NS     = 7812,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned AP_BIT        = 10,
  parameter int unsigned MODE_WORD     = 'h023
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done,
  output logic              refresh_req
);

  localparam int unsigned SETTLE_CYC = ns_to_cycles(T_SETTLE_NS, CLK_HZ);
  localparam int unsigned RP_CYC     = ns_to_cycles(T_RP_NS, CLK_HZ);
  localparam int unsigned RFC_CYC    = ns_to_cycles(T_RFC_NS, CLK_HZ);
  localparam int unsigned MRD_CYC    = ns_to_cycles(T_MRD_NS, CLK_HZ);
  localparam int unsigned REFI_CYC   = ns_to_cycles(T_REFI_NS, CLK_HZ);
  localparam int unsigned MAX_CYC    = max2(max2(SETTLE_CYC, RP_CYC), max2(RFC_CYC, MRD_CYC));
  localparam int unsigned TMR_W      = $clog2(MAX_CYC + 1);
  localparam int unsigned REF_W      = $clog2(REFRESH_COUNT + 1);

  seq_state_e        state_q, state_nxt;
  logic [REF_W-1:0]  refs_q, refs_nxt;
  logic              done_q, done_nxt;
  sd_cmd_e           cmd_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_expired;

  seq_countdown #(.W(TMR_W), .RST_VAL(SETTLE_CYC)) u_gap_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  // next command is chosen the cycle the spacing timer runs out
  always_comb begin
    state_nxt = state_q;
    refs_nxt  = refs_q;
    done_nxt  = done_q;
    cmd_nxt   = CMD_NOP;
    addr_nxt  = '0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (state_q)
      ST_SETTLE: if (tmr_expired) begin
        cmd_nxt          = CMD_PRECHARGE;
        addr_nxt[AP_BIT] = 1'b1;
        tmr_load         = 1'b1;
        tmr_val          = TMR_W'(RP_CYC - 1);
        state_nxt        = ST_AFTER_PRE;
      end
      ST_AFTER_PRE: if (tmr_expired) begin
        cmd_nxt   = CMD_REFRESH;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(RFC_CYC - 1);
        refs_nxt  = REF_W'(1);
        state_nxt = ST_AFTER_REF;
      end
      ST_AFTER_REF: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (refs_q == REF_W'(REFRESH_COUNT)) begin
          cmd_nxt   = CMD_LOAD_MODE;
          addr_nxt  = ADDR_W'(MODE_WORD);
          tmr_val   = TMR_W'(MRD_CYC - 1);
          state_nxt = ST_AFTER_MODE;
        end else begin
          cmd_nxt  = CMD_REFRESH;
          tmr_val  = TMR_W'(RFC_CYC - 1);
          refs_nxt = refs_q + 1'b1;
        end
      end
      ST_AFTER_MODE: if (tmr_expired) begin
        done_nxt  = 1'b1;
        state_nxt = ST_READY;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SETTLE;
      refs_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      refs_q  <= refs_nxt;
      done_q  <= done_nxt;
    end
  end

  sdram_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd_reg (
    .clk     (clk),
    .rst     (rst),
    .cmd_in  (cmd_nxt),
    .addr_in (addr_nxt),
    .cke     (sd_cke),
    .cs_n    (sd_cs_n),
    .ras_n   (sd_ras_n),
    .cas_n   (sd_cas_n),
    .we_n    (sd_we_n),
    .addr    (sd_addr)
  );

  refresh_tick_gen #(.PERIOD(REFI_CYC)) u_refresh_tick (
    .clk    (clk),
    .rst    (rst),
    .enable (done_q),
    .tick   (refresh_req)
  );

  assign sd_ba     = '0;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 50_000_000,
  parameter int unsigned T_SETTLE_NS   = 100_000,
  parameter int unsigned REFRESH_COUNT = 2,
  parameter int unsigned T_RP_NS       = 20,
  parameter int unsigned T_RFC_NS      = 66,
  parameter int unsigned T_MRD_NS      = 20,
  parameter int unsigned T_REFI_NS     = 7812,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned AP_BIT        = 10,
  parameter int unsigned MODE_WORD     = 'h023
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done,
  input logic              refresh_req
);

  localparam int unsigned SETTLE_CYC = ns_to_cycles(T_SETTLE_NS, CLK_HZ);
  localparam int unsigned RP_CYC     = ns_to_cycles(T_RP_NS, CLK_HZ);
  localparam int unsigned RFC_CYC    = ns_to_cycles(T_RFC_NS, CLK_HZ);
  localparam int unsigned MRD_CYC    = ns_to_cycles(T_MRD_NS, CLK_HZ);
  localparam int unsigned REFI_CYC   = ns_to_cycles(T_REFI_NS, CLK_HZ);

  logic [3:0]  pins;
  logic        is_nop, is_pre, is_ref, is_mode;
  int unsigned up_cyc, since, refs, tick_gap;
  logic [1:0]  last_kind;   // 0 none, 1 precharge, 2 refresh, 3 mode load

  assign pins    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop  = (pins == 4'b0111);
  assign is_pre  = (pins == 4'b0010);
  assign is_ref  = (pins == 4'b0001);
  assign is_mode = (pins == 4'b0000);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_cyc    <= 0;
      since     <= 0;
      refs      <= 0;
      last_kind <= 2'd0;
      tick_gap  <= 0;
    end else begin
      if (up_cyc != 32'hFFFF_FFFF) up_cyc <= up_cyc + 1;
      if (!is_nop) begin
        since <= 1;
        if (is_pre)  last_kind <= 2'd1;
        if (is_ref)  last_kind <= 2'd2;
        if (is_mode) last_kind <= 2'd3;
        if (is_ref)  refs <= refs + 1;
      end else if (since != 32'hFFFF_FFFF) begin
        since <= since + 1;
      end
      if (!init_done)       tick_gap <= 0;
      else if (refresh_req) tick_gap <= 1;
      else                  tick_gap <= tick_gap + 1;
    end
  end

  assert_settle_wait_R3: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (up_cyc >= SETTLE_CYC && last_kind == 2'd0));
  assert_precharge_a10_R3: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> sd_addr[AP_BIT]);
  assert_rp_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (is_ref && last_kind == 2'd1) |-> since >= RP_CYC);
  assert_rfc_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    ((is_ref || is_mode) && last_kind == 2'd2) |-> since >= RFC_CYC);
  assert_mode_word_R5: assert property (@(posedge clk) disable iff (rst)
    is_mode |-> (sd_addr == ADDR_W'(MODE_WORD) && sd_ba == '0 && refs == REFRESH_COUNT));
  assert_cke_hold_R2: assert property (@(posedge clk) disable iff (rst)
    sd_cke |=> sd_cke);
  assert_cs_low_R2: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n);
  assert_done_after_mrd_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (last_kind == 2'd3 && since >= MRD_CYC));
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_nop);
  assert_tick_gated_R8: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> init_done);
  assert_tick_interval_R8: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> tick_gap == REFI_CYC);
  assert_known_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    (is_nop || is_pre || is_ref || is_mode));

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .CLK_HZ(CLK_HZ), .T_SETTLE_NS(T_SETTLE_NS), .REFRESH_COUNT(REFRESH_COUNT),
  .T_RP_NS(T_RP_NS), .T_RFC_NS(T_RFC_NS), .T_MRD_NS(T_MRD_NS),
  .T_REFI_NS(T_REFI_NS), .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT),
  .MODE_WORD(MODE_WORD)
) u_seq_chk (
  .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done),
  .refresh_req(refresh_req)
);

// File: tb/sdram_powerup_seq_tb_top.sv
module sdram_powerup_seq_tb_top;

  typedef struct {
    logic [3:0]  pins;
    logic [12:0] addr;
    int          lo;
    int          hi;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke_w   [2];
  logic        cs_w    [2];
  logic        ras_w   [2];
  logic        cas_w   [2];
  logic        we_w    [2];
  logic [1:0]  ba_w    [2];
  logic [12:0] addr_w  [2];
  logic        done_w  [2];
  logic        req_w   [2];

  exp_t exp_q0[$];
  exp_t exp_q1[$];
  int   total = 0;
  int   bad   = 0;
  bit   ended = 1'b0;

  always #10 clk = ~clk;

  sdram_powerup_seq dut_i (
    .clk(clk), .rst(rst), .sd_cke(cke_w[0]), .sd_cs_n(cs_w[0]),
    .sd_ras_n(ras_w[0]), .sd_cas_n(cas_w[0]), .sd_we_n(we_w[0]),
    .sd_ba(ba_w[0]), .sd_addr(addr_w[0]), .init_done(done_w[0]),
    .refresh_req(req_w[0])
  );

  sdram_powerup_seq #(
    .T_SETTLE_NS(200_000), .REFRESH_COUNT(8), .T_RP_NS(10),
    .T_RFC_NS(130), .T_REFI_NS(3000)
  ) dut_j (
    .clk(clk), .rst(rst), .sd_cke(cke_w[1]), .sd_cs_n(cs_w[1]),
    .sd_ras_n(ras_w[1]), .sd_cas_n(cas_w[1]), .sd_we_n(we_w[1]),
    .sd_ba(ba_w[1]), .sd_addr(addr_w[1]), .init_done(done_w[1]),
    .refresh_req(req_w[1])
  );

  // R6: bench-side conversion at 50 MHz, floor and at least 1
  function automatic int cyc(input int ns);
    int c;
    c = (ns * 50) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push_item(input int idx, input exp_t e);
    if (idx == 0) exp_q0.push_back(e);
    else          exp_q1.push_back(e);
  endtask

  // driver: expected command list from the requirements
  task automatic push_plan(input int idx, input int settle_ns, input int nref,
                           input int rp_ns, input int rfc_ns);
    exp_t e;
    e.pins = 4'b0010; e.addr = 13'h0400;
    e.lo = cyc(settle_ns); e.hi = cyc(settle_ns) + 1; e.req = "R3";
    push_item(idx, e);
    for (int k = 0; k < nref; k++) begin
      e.pins = 4'b0001; e.addr = 13'h0;
      e.lo = (k == 0) ? cyc(rp_ns) : cyc(rfc_ns);
      e.hi = e.lo; e.req = "R4";
      push_item(idx, e);
    end
    e.pins = 4'b0000; e.addr = 13'h023;
    e.lo = cyc(rfc_ns); e.hi = e.lo; e.req = "R5";
    push_item(idx, e);
  endtask

  // monitor: pops expected items as commands appear on the pins
  task automatic watch(input int idx, input int mrd, input int refi);
    int   n = 0;
    int   last_cmd = 0;
    int   mode_n = -1;
    int   done_n = -1;
    int   last_tick = -1;
    int   ticks = 0;
    logic [3:0] pins;
    exp_t e;
    while (ticks < 3) begin
      @(negedge clk);
      n++;
      pins = {cs_w[idx], ras_w[idx], cas_w[idx], we_w[idx]};
      if (n == 1) check(cke_w[idx] == 1'b0, "R2", "cke first cycle", int'(cke_w[idx]), 0);
      if (n == 2) check(cke_w[idx] == 1'b1, "R2", "cke second cycle", int'(cke_w[idx]), 1);
      if (pins != 4'b0111) begin
        check(done_w[idx] == 1'b0, "R7", "command after init_done", int'(pins), 7);
        if ((idx == 0 && exp_q0.size() == 0) || (idx == 1 && exp_q1.size() == 0)) begin
          check(1'b0, "R9", "unexpected command", int'(pins), 7);
        end else begin
          e = (idx == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
          check(pins == e.pins, e.req, "command encoding", int'(pins), int'(e.pins));
          check(addr_w[idx] == e.addr, e.req, "address", int'(addr_w[idx]), int'(e.addr));
          check((n - last_cmd) >= e.lo && (n - last_cmd) <= e.hi, e.req,
                "spacing", n - last_cmd, e.lo);
          check(cke_w[idx] && !cs_w[idx], "R2", "cke high, cs low at command",
                int'({cke_w[idx], cs_w[idx]}), 2);
          if (pins == 4'b0000) begin
            mode_n = n;
            check(ba_w[idx] == 2'b00, "R5", "bank bits", int'(ba_w[idx]), 0);
            check(addr_w[idx][2:0] == 3'b011 && addr_w[idx][3] == 1'b0 &&
                  addr_w[idx][6:4] == 3'b010, "R5", "mode fields",
                  int'(addr_w[idx][6:0]), 'h23);
          end
          last_cmd = n;
        end
      end
      if (done_n < 0 && done_w[idx]) begin
        done_n = n;
        check(mode_n > 0 && (n - mode_n) == mrd, "R7", "init_done delay", n - mode_n, mrd);
        check(((idx == 0) ? exp_q0.size() : exp_q1.size()) == 0, "R4",
              "commands left at init_done", (idx == 0) ? exp_q0.size() : exp_q1.size(), 0);
      end
      if (done_n >= 0 && !done_w[idx])
        check(1'b0, "R7", "init_done dropped", 0, 1);
      if (req_w[idx]) begin
        check(done_w[idx] == 1'b1, "R8", "refresh_req before init_done", 0, 1);
        check((n - ((last_tick < 0) ? done_n : last_tick)) == refi, "R8",
              "refresh interval", n - ((last_tick < 0) ? done_n : last_tick), refi);
        last_tick = n;
        ticks++;
      end
    end
  endtask

  initial begin
    push_plan(0, 100_000, 2, 20, 66);
    push_plan(1, 200_000, 8, 10, 130);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check(cke_w[k] == 1'b0, "R1", "cke in reset", int'(cke_w[k]), 0);
      check({cs_w[k], ras_w[k], cas_w[k], we_w[k]} == 4'b0111, "R1", "NOP in reset",
            int'({cs_w[k], ras_w[k], cas_w[k], we_w[k]}), 7);
      check(done_w[k] == 1'b0 && req_w[k] == 1'b0, "R1", "flags in reset",
            int'({done_w[k], req_w[k]}), 0);
    end
    rst = 1'b0;
    fork
      watch(0, cyc(20), cyc(7812));
      watch(1, cyc(20), cyc(3000));
    join
    check(exp_q0.size() == 0 && exp_q1.size() == 0, "R9", "unissued commands",
          exp_q0.size() + exp_q1.size(), 0);
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule